// File: doc/BRIEF.md
# Block Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no storage. The operand width is cut into equal groups of columns. For every column it forms a generate term (both operand bits set) and a propagate term (either operand bit set). Each group folds its column terms into one group generate and one group propagate. The carry into the next group then comes from a single AND-OR step: the group generate, OR the group propagate AND the carry into the group.

Inside a group the sum bits come from an ordinary short carry chain that starts from the group's carry-in. A carry that crosses the whole word therefore passes through one AND-OR step per group instead of one per column. The block is intended as the add stage of a larger datapath that registers its inputs and outputs elsewhere.

The data pins are plain combinational vectors. There is no valid/ready handshake because nothing is held or queued, so no back-pressure applies. The width must be a whole multiple of the group size, and elaboration stops otherwise.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `opa_i + opb_i + cin_i`, taken as unsigned values.
- R2: `cout_o` equals bit WIDTH of that same unsigned total, which is the carry out of the most significant column.
- R3: When `opb_i` is the bitwise complement of `opa_i`, every column propagates. With `cin_i`=0 the outputs are `sum_o` all ones and `cout_o`=0. With `cin_i`=1 they are `sum_o`=0 and `cout_o`=1; for example, all-ones plus zero plus a carry-in of 1 gives this result.
- R4: When both operand bits are set in the top column of a group (column BLK*j+BLK-1 for group j), a carry enters group j+1 whatever `cin_i` is.
- R5: When every column of a group has both operand bits clear, no carry leaves that group, even if carries arrive from below it.
- R6: The outputs do not change when the two operands are swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand, unsigned |
| opb_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into column 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of the top column |

## Verification
The hardest case is the carry that must cross every group: all ones plus a carry-in of 1, and operands that are complements of each other. A wrong propagate term or a broken step between groups leaves a band of ones in the sum, or drops the carry-out. At each group boundary, a generate placed in the group's top column must set the first bit of the next group; an off-by-one in the group slicing moves that bit or loses it. Groups whose columns are all clear must stop a carry that arrives from below, which exposes a propagate that is stuck high. Alternating bit patterns and random vectors, each tried with both operand orders, catch sum bits wired to the wrong column carry.

// File: rtl/la_pkg.sv
package la_pkg;
  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;
endpackage

// File: rtl/la_col_pg.sv
module la_col_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i | b_i;
endmodule

// File: rtl/la_grp_gp.sv
module la_grp_gp
  import la_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output gp_t          gp_o
);
  always_comb begin
    gp_o.gen  = g_i[0];
    gp_o.prop = p_i[0];
    for (int i = 1; i < W; i++) begin
      gp_o.gen  = g_i[i] | (p_i[i] & gp_o.gen);
      gp_o.prop = p_i[i] & gp_o.prop;
    end
  end
endmodule

// File: rtl/la_grp_sum.sv
module la_grp_sum #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         c_i,
  output logic [W-1:0] s_o
);
  logic c;
  always_comb begin
    c = c_i;
    for (int i = 0; i < W; i++) begin
      s_o[i] = a_i[i] ^ b_i[i] ^ c;
      c      = g_i[i] | (p_i[i] & c);
    end
  end
endmodule

// File: rtl/la_carry_step.sv
module la_carry_step
  import la_pkg::*;
(
  input  gp_t  gp_i,
  input  logic c_i,
  output logic c_o
);
  assign c_o = gp_i.gen | (gp_i.prop & c_i);
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import la_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NGRP = WIDTH / BLK;

  if ((WIDTH % BLK) != 0 || BLK < 1) begin : g_bad_cfg
    $error("WIDTH must be a multiple of BLK");
  end

  logic [NGRP:0] grp_c;
  gp_t           grp_gp [NGRP];

  assign grp_c[0] = cin_i;

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    logic [BLK-1:0] g;
    logic [BLK-1:0] p;

    la_col_pg #(.W(BLK)) u_pg (
      .a_i (opa_i[j*BLK +: BLK]),
      .b_i (opb_i[j*BLK +: BLK]),
      .g_o (g),
      .p_o (p)
    );

    la_grp_gp #(.W(BLK)) u_gp (
      .g_i  (g),
      .p_i  (p),
      .gp_o (grp_gp[j])
    );

    la_carry_step u_step (
      .gp_i (grp_gp[j]),
      .c_i  (grp_c[j]),
      .c_o  (grp_c[j+1])
    );

    la_grp_sum #(.W(BLK)) u_sum (
      .a_i (opa_i[j*BLK +: BLK]),
      .b_i (opb_i[j*BLK +: BLK]),
      .g_i (g),
      .p_i (p),
      .c_i (grp_c[j]),
      .s_o (sum_o[j*BLK +: BLK])
    );
  end

  assign cout_o = grp_c[NGRP];
endmodule

// File: rtl/la_adder_chk.sv
module la_adder_chk #(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input logic [WIDTH-1:0]      opa_i,
  input logic [WIDTH-1:0]      opb_i,
  input logic                  cin_i,
  input logic [WIDTH-1:0]      sum_o,
  input logic                  cout_o,
  input logic [WIDTH/BLK:0]    grp_c
);
  localparam int NGRP = WIDTH / BLK;
  logic [WIDTH:0] total;

  always_comb begin
    total = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, cin_i};
    AST_SUM_VALUE: assert (sum_o == total[WIDTH-1:0]) else $error("sum mismatch"); // R1
    AST_CARRY_OUT: assert (cout_o == total[WIDTH]) else $error("carry-out mismatch"); // R2
    if (opb_i == ~opa_i) begin
      AST_FULL_PROP: assert ((cout_o == cin_i) && (sum_o == {WIDTH{~cin_i}})) else $error("full propagate wrong"); // R3
    end
    for (int j = 0; j < NGRP; j++) begin
      if (opa_i[j*BLK+BLK-1] && opb_i[j*BLK+BLK-1]) begin
        AST_GRP_GEN: assert (grp_c[j+1]) else $error("group generate lost"); // R4
      end
      if ((opa_i[j*BLK +: BLK] | opb_i[j*BLK +: BLK]) == '0) begin
        AST_GRP_KILL: assert (!grp_c[j+1]) else $error("group kill leaked"); // R5
      end
    end
  end
endmodule

bind lookahead_adder la_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .grp_c  (grp_c)
);

// File: tb/lookahead_adder_tb.sv
module lookahead_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 32;
  localparam int BLK   = 4;
  localparam int NGRP  = WIDTH / BLK;

  logic             clk = 1'b0;
  logic [WIDTH-1:0] a, b, s;
  logic             ci, co;
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lookahead_adder #(.WIDTH(WIDTH), .BLK(BLK)) u_dut (
    .opa_i (a), .opb_i (b), .cin_i (ci), .sum_o (s), .cout_o (co)
  );

  task automatic apply(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y, input logic c);
    a = x; b = y; ci = c;
    #(CLK_PERIOD/2);
  endtask

  task automatic check(input string req, input logic [WIDTH:0] got, input logic [WIDTH:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [WIDTH:0] ref_add(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c};
  endfunction

  task automatic run_vec(input string req, input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y, input logic c);
    apply(x, y, c);
    check(req, {co, s}, ref_add(x, y, c));
  endtask

  task automatic t_zero();
    run_vec("R1 zero operands", '0, '0, 1'b0);
    run_vec("R2 zero operands cin", '0, '0, 1'b1);
  endtask

  task automatic t_full_prop();
    apply('1, '0, 1'b1);
    check("R3 all ones plus cin", {co, s}, {1'b1, {WIDTH{1'b0}}});
    apply(32'h5A3C_0F96, ~32'h5A3C_0F96, 1'b0);
    check("R3 complement cin0", {co, s}, {1'b0, {WIDTH{1'b1}}});
    apply(32'h5A3C_0F96, ~32'h5A3C_0F96, 1'b1);
    check("R3 complement cin1", {co, s}, {1'b1, {WIDTH{1'b0}}});
  endtask

  task automatic t_alternating();
    run_vec("R1 alt AAAA+5555", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    run_vec("R2 alt AAAA+AAAA", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    run_vec("R2 alt 5555+5555", 32'h5555_5555, 32'h5555_5555, 1'b0);
    run_vec("R2 msb carry", 32'h8000_0000, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_grp_gen();
    for (int j = 0; j < NGRP - 1; j++) begin
      logic [WIDTH-1:0] v;
      v = '0;
      v[j*BLK+BLK-1] = 1'b1;
      apply(v, v, 1'b0);
      check("R4 group generate", {31'b0, s[(j+1)*BLK], co}, {31'b0, 1'b1, 1'b0});
    end
  endtask

  task automatic t_grp_kill();
    for (int j = 1; j < NGRP; j++) begin
      logic [WIDTH-1:0] v;
      v = '1;
      v[j*BLK +: BLK] = '0;
      apply(v, 32'h1, 1'b1);
      check("R5 group kill", {co, s}, ref_add(v, 32'h1, 1'b1));
    end
  endtask

  task automatic t_swap();
    logic [WIDTH:0] r1;
    apply(32'h1234_5678, 32'hFEDC_BA98, 1'b1);
    r1 = {co, s};
    apply(32'hFEDC_BA98, 32'h1234_5678, 1'b1);
    check("R6 operand swap", {co, s}, r1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      logic [WIDTH-1:0] x, y;
      logic c;
      x = $urandom; y = $urandom; c = 1'($urandom);
      run_vec("R1 R2 random", x, y, c);
      run_vec("R6 random swapped", y, x, c);
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    @(negedge clk);
    t_zero();
    t_full_prop();
    t_alternating();
    t_grp_gen();
    t_grp_kill();
    t_swap();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule